// File: doc/BRIEF.md
# Interrupt Line State Register Bank

This block keeps three state bits for each of a parameterised number of maskable interrupt lines (60 by default): enabled, pending and active. The bits are packed one per line into 32-bit words. A plain synchronous register port reaches them. Enable and pending state each have a view that only sets bits and a view that only clears them, so software changes single lines without a read-modify-write. The active bits can be read but not written.

Raw request inputs are edge-detected, and a rising request marks its line pending. The block presents every line that is both enabled and pending to a downstream arbiter. The arbiter replies with two strobes. An acknowledge strobe moves the chosen line from pending to active. A completion strobe later drops the active bit. Priority storage, arbitration and vector fetch are handled elsewhere.

Top module: `irq_state_bank`

## Requirements
- R1: While reset is high and just after it is released, the enable, pending and active bits are all 0, `req_out` and `active_out` are 0, and `bus_rdata` is 0.
- R2: `bus_addr` is `{view[2:0], word}`. Line n sits at bit n%32 of word n/32, so lines 0–31 are bits 0–31 of word 0 and lines 32–59 are bits 0–27 of word 1. Bits 28–31 of word 1 read as 0 in every view and ignore writes.
- R3: Enable-set view (view 0): each 1 written enables that line, and each 0 written leaves its line unchanged.
- R4: Enable-clear view (view 1): each 1 written disables that line, and each 0 written leaves its line unchanged.
- R5: Pending-set view (view 2): each 1 written marks that line pending, and each 0 written has no effect.
- R6: Pending-clear view (view 3): each 1 written removes the pending state, and each 0 written has no effect.
- R7: Reading the set view or the clear view of a state returns the current bits of that state.
- R8: Active view (view 4) returns the active bits and ignores writes. Views 5–7 read as 0 and ignore writes. Active bits change only on acknowledge or completion.
- R9: A 0-to-1 change on `irq_in[n]` sets pending bit n whether or not the line is enabled. A request held high does not set the bit again after it is cleared.
- R10: `req_out[n]` is 1 exactly when line n is both enabled and pending.
- R11: `ack_valid` with `ack_id`=n clears pending bit n and sets active bit n on the same edge. `done_valid` with `done_id`=n clears active bit n. Identifiers of NUM_LINES or more have no effect.
- R12: When a set and a clear of the same bit meet on one edge, the set wins. This covers a request rise with a pending-clear write or an acknowledge, and an acknowledge with a completion.
- R13: A read (`bus_sel`=1, `bus_we`=0) loads `bus_rdata` on that clock edge. `bus_rdata` then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (4) | `{view, word}` address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq_in | input | NUM_LINES (60) | Raw interrupt request levels |
| ack_valid | input | 1 | Arbiter acknowledge strobe |
| ack_id | input | ID_W (6) | Line being acknowledged |
| done_valid | input | 1 | Service completion strobe |
| done_id | input | ID_W (6) | Line whose service finished |
| req_out | output | NUM_LINES (60) | Lines both enabled and pending |
| active_out | output | NUM_LINES (60) | Lines in service |

## Verification
Every state change lands on the clock edge that samples the write, request rise, acknowledge or completion. `req_out` and `active_out` follow combinationally from those bits, so they are valid from the next falling edge. A read result is registered on the edge that samples the read. The bench drives all inputs on falling edges. It checks a read result at the falling edge right after its read edge, and it checks outputs one falling edge after the edge that caused the change. A separate check confirms that the read data holds through idle cycles.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int DATA_W = 32;
    localparam int VIEW_W = 3;

    // Register views selected by the upper address bits
    localparam logic [VIEW_W-1:0] VIEW_EN_SET = 3'd0;
    localparam logic [VIEW_W-1:0] VIEW_EN_CLR = 3'd1;
    localparam logic [VIEW_W-1:0] VIEW_PD_SET = 3'd2;
    localparam logic [VIEW_W-1:0] VIEW_PD_CLR = 3'd3;
    localparam logic [VIEW_W-1:0] VIEW_ACTIVE = 3'd4;

    // One-hot decode of a bus write
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
    } wr_hit_t;

    function automatic int word_count(input int lines);
        return (lines + DATA_W - 1) / DATA_W;
    endfunction

    function automatic int word_bits(input int lines);
        int w;
        w = word_count(lines);
        return (w <= 1) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/irq_rise_detect.sv
module irq_rise_detect #(
    parameter int W = 60
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/irq_set_clr_reg.sv
module irq_set_clr_reg #(
    parameter int W = 60
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    // Every requested set lands, even against a clear on the same edge
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

    // A clear without a competing set drops the bit
    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((q & $past(clr_i & ~set_i)) == '0));

    // Bits that nobody touches keep their value
    assert_untouched_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((set_i | clr_i) == '0) |=> $stable(q));

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 60,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic [NUM_LINES-1:0] en_q_i,
    input  logic [NUM_LINES-1:0] pd_q_i,
    input  logic [NUM_LINES-1:0] act_q_i,
    output logic [NUM_LINES-1:0] en_set_o,
    output logic [NUM_LINES-1:0] en_clr_o,
    output logic [NUM_LINES-1:0] pd_set_o,
    output logic [NUM_LINES-1:0] pd_clr_o,
    output logic [DATA_W-1:0]    rdata_o
);
    localparam int WORDS  = word_count(NUM_LINES);
    localparam int WORD_W = word_bits(NUM_LINES);
    localparam int PAD    = WORDS * DATA_W;
    localparam int SPARE  = PAD - NUM_LINES;

    logic [VIEW_W-1:0]    view;
    logic [WORD_W-1:0]    word;
    logic                 word_ok;
    wr_hit_t              hit;
    logic [NUM_LINES-1:0] wmask;
    logic [PAD-1:0]       en_pad, pd_pad, act_pad;
    logic [DATA_W-1:0]    rd_word;
    logic [DATA_W-1:0]    rdata_q;

    assign view    = addr_i[ADDR_W-1 -: VIEW_W];
    assign word    = addr_i[WORD_W-1:0];
    assign word_ok = (int'(word) < WORDS);

    always_comb begin
        hit = '0;
        if (sel_i && we_i && word_ok) begin
            hit.en_set = (view == VIEW_EN_SET);
            hit.en_clr = (view == VIEW_EN_CLR);
            hit.pd_set = (view == VIEW_PD_SET);
            hit.pd_clr = (view == VIEW_PD_CLR);
        end
    end

    // Each line picks its data bit from the addressed word
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
        assign wmask[i] = wdata_i[i % DATA_W] && (int'(word) == i / DATA_W);
    end

    assign en_set_o = hit.en_set ? wmask : '0;
    assign en_clr_o = hit.en_clr ? wmask : '0;
    assign pd_set_o = hit.pd_set ? wmask : '0;
    assign pd_clr_o = hit.pd_clr ? wmask : '0;

    assign en_pad  = PAD'(en_q_i);
    assign pd_pad  = PAD'(pd_q_i);
    assign act_pad = PAD'(act_q_i);

    always_comb begin
        rd_word = '0;
        if (word_ok) begin
            case (view)
                VIEW_EN_SET, VIEW_EN_CLR: rd_word = en_pad[int'(word)*DATA_W +: DATA_W];
                VIEW_PD_SET, VIEW_PD_CLR: rd_word = pd_pad[int'(word)*DATA_W +: DATA_W];
                VIEW_ACTIVE:              rd_word = act_pad[int'(word)*DATA_W +: DATA_W];
                default:                  rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 rdata_q <= '0;
        else if (sel_i && !we_i) rdata_q <= rd_word;
    end

    assign rdata_o = rdata_q;

    // Read data only moves on a read
    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !(sel_i && !we_i) |=> $stable(rdata_q));

    if (SPARE > 0) begin : g_spare_chk
        // Unbacked bits of the last word always read as zero
        assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
            (sel_i && !we_i && int'(word) == WORDS - 1)
            |=> (rdata_q[DATA_W-1 -: SPARE] == '0));
    end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 60,
    parameter int ID_W      = $clog2(NUM_LINES),
    parameter int ADDR_W    = irq_bank_pkg::VIEW_W + irq_bank_pkg::word_bits(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [ID_W-1:0]      ack_id,
    input  logic                 done_valid,
    input  logic [ID_W-1:0]      done_id,
    output logic [NUM_LINES-1:0] req_out,
    output logic [NUM_LINES-1:0] active_out
);
    logic [NUM_LINES-1:0] en_set, en_clr, pd_set_bus, pd_clr_bus;
    logic [NUM_LINES-1:0] rise, ack_mask, done_mask;
    logic [NUM_LINES-1:0] en_q, pd_q, act_q;

    irq_bus_port #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_port (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (bus_sel),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .en_q_i   (en_q),
        .pd_q_i   (pd_q),
        .act_q_i  (act_q),
        .en_set_o (en_set),
        .en_clr_o (en_clr),
        .pd_set_o (pd_set_bus),
        .pd_clr_o (pd_clr_bus),
        .rdata_o  (bus_rdata)
    );

    irq_rise_detect #(.W(NUM_LINES)) u_rise (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (irq_in),
        .rise_o (rise)
    );

    // Identifier decode; out-of-range values match no line
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
        assign ack_mask[i]  = ack_valid  && (ack_id  == ID_W'(i));
        assign done_mask[i] = done_valid && (done_id == ID_W'(i));
    end

    irq_set_clr_reg #(.W(NUM_LINES)) u_enable (
        .clk (clk), .rst (rst),
        .set_i (en_set), .clr_i (en_clr), .q_o (en_q)
    );

    irq_set_clr_reg #(.W(NUM_LINES)) u_pending (
        .clk (clk), .rst (rst),
        .set_i (pd_set_bus | rise), .clr_i (pd_clr_bus | ack_mask), .q_o (pd_q)
    );

    irq_set_clr_reg #(.W(NUM_LINES)) u_active (
        .clk (clk), .rst (rst),
        .set_i (ack_mask), .clr_i (done_mask), .q_o (act_q)
    );

    assign req_out    = en_q & pd_q;
    assign active_out = act_q;

    // Acknowledge puts the line in service
    assert_ack_active_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && int'(ack_id) < NUM_LINES) |=> act_q[$past(ack_id)]);

    // Acknowledge retires the pending state unless a new set competes
    assert_ack_unpend_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && int'(ack_id) < NUM_LINES
         && !rise[ack_id] && !pd_set_bus[ack_id]) |=> !pd_q[$past(ack_id)]);

    // Active bits move only through the arbiter strobes
    assert_active_hw_only_R8: assert property (@(posedge clk) disable iff (rst)
        (!ack_valid && !done_valid) |=> $stable(act_q));

    // A request edge always leaves its line pending
    assert_rise_pends_R9: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pd_q & $past(rise)) == $past(rise)));

endmodule

// File: tb/sim_irq_state_bank.sv
module sim_irq_state_bank;

    localparam int NL = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NL-1:0] irq_in = '0;
    logic        ack_valid = 1'b0;
    logic [5:0]  ack_id = '0;
    logic        done_valid = 1'b0;
    logic [5:0]  done_id = '0;
    logic [NL-1:0] req_out, active_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_state_bank u0 (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .done_valid(done_valid), .done_id(done_id),
        .req_out(req_out), .active_out(active_out)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    // Address = {view, word}: views 0 en-set, 1 en-clr, 2 pd-set, 3 pd-clr, 4 active
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0,  32'hA5A5_0000, 32'h0,         8'd3},  // R3
        '{1'b0, 4'd0,  32'h0,         32'hA5A5_0000, 8'd3},  // R3
        '{1'b0, 4'd2,  32'h0,         32'hA5A5_0000, 8'd7},  // R7
        '{1'b1, 4'd0,  32'h0,         32'h0,         8'd3},  // R3 zeros
        '{1'b0, 4'd0,  32'h0,         32'hA5A5_0000, 8'd3},  // R3
        '{1'b1, 4'd1,  32'hFFFF_FFFF, 32'h0,         8'd2},  // R2
        '{1'b0, 4'd1,  32'h0,         32'h0FFF_FFFF, 8'd2},  // R2
        '{1'b1, 4'd2,  32'h0005_0000, 32'h0,         8'd4},  // R4
        '{1'b0, 4'd0,  32'h0,         32'hA5A0_0000, 8'd4},  // R4
        '{1'b1, 4'd3,  32'h0,         32'h0,         8'd4},  // R4 zeros
        '{1'b0, 4'd3,  32'h0,         32'h0FFF_FFFF, 8'd7},  // R7
        '{1'b1, 4'd3,  32'h0800_0001, 32'h0,         8'd4},  // R4
        '{1'b0, 4'd1,  32'h0,         32'h07FF_FFFE, 8'd4},  // R4
        '{1'b1, 4'd4,  32'h0000_00F0, 32'h0,         8'd5},  // R5
        '{1'b0, 4'd4,  32'h0,         32'h0000_00F0, 8'd5},  // R5
        '{1'b0, 4'd6,  32'h0,         32'h0000_00F0, 8'd7},  // R7
        '{1'b1, 4'd5,  32'h1000_0003, 32'h0,         8'd2},  // R2
        '{1'b0, 4'd5,  32'h0,         32'h0000_0003, 8'd2},  // R2
        '{1'b1, 4'd6,  32'h0000_0030, 32'h0,         8'd6},  // R6
        '{1'b0, 4'd4,  32'h0,         32'h0000_00C0, 8'd6},  // R6
        '{1'b1, 4'd6,  32'h0,         32'h0,         8'd6},  // R6 zeros
        '{1'b0, 4'd6,  32'h0,         32'h0000_00C0, 8'd6},  // R6
        '{1'b1, 4'd8,  32'hFFFF_FFFF, 32'h0,         8'd8},  // R8
        '{1'b0, 4'd8,  32'h0,         32'h0,         8'd8},  // R8
        '{1'b0, 4'd9,  32'h0,         32'h0,         8'd8},  // R8
        '{1'b1, 4'd10, 32'hFFFF_FFFF, 32'h0,         8'd8},  // R8
        '{1'b0, 4'd10, 32'h0,         32'h0,         8'd8},  // R8
        '{1'b0, 4'd0,  32'h0,         32'hA5A0_0000, 8'd8},  // R8
        '{1'b1, 4'd11, 32'hFFFF_FFFF, 32'h0,         8'd8},  // R8
        '{1'b0, 4'd1,  32'h0,         32'h07FF_FFFE, 8'd8}   // R8
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rdata after reset", 64'(bus_rdata), 64'h0);
        check("R1 req_out after reset", 64'(req_out), 64'h0);
        check("R1 active_out after reset", 64'(active_out), 64'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                checks++;
                if (rd !== VECS[i].exp) begin
                    errors++;
                    $display("FAIL R%0d row %0d actual=%h expected=%h",
                             VECS[i].req, i, rd, VECS[i].exp);
                end
            end
        end

        // R10: enables w0=A5A00000, w1=07FFFFFE; pending w0=C0, w1=3 -> only line 33
        check("R10 req_out overlap", 64'(req_out), 64'(60'h2_0000_0000));

        // R9: edge on an unenabled line
        bus_write(4'd6, 32'hFFFF_FFFF);
        bus_write(4'd7, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_in[5] = 1'b1;
        bus_read(4'd4, rd);
        check("R9 rise pends disabled line", 64'(rd), 64'h20);
        check("R10 disabled line not requested", 64'(req_out), 64'h0);
        bus_write(4'd6, 32'h20);
        bus_read(4'd4, rd);
        check("R9 held level does not re-pend", 64'(rd), 64'h0);
        @(negedge clk);
        irq_in[5] = 1'b0;

        // R11: line 40 is word1 bit 8, already enabled
        bus_write(4'd5, 32'h100);
        @(negedge clk);
        check("R10 line 40 requested", 64'(req_out), 64'(60'h100_0000_0000));
        ack_valid = 1'b1; ack_id = 6'd40;
        @(negedge clk);
        ack_valid = 1'b0;
        check("R11 ack sets active", 64'(active_out), 64'(60'h100_0000_0000));
        check("R11 ack drops request", 64'(req_out), 64'h0);
        bus_read(4'd5, rd);
        check("R11 ack clears pending", 64'(rd), 64'h0);
        bus_read(4'd9, rd);
        check("R11 active view word1", 64'(rd), 64'h100);
        @(negedge clk);
        done_valid = 1'b1; done_id = 6'd40;
        @(negedge clk);
        done_valid = 1'b0;
        check("R11 done clears active", 64'(active_out), 64'h0);
        ack_valid = 1'b1; ack_id = 6'd62;
        done_valid = 1'b1; done_id = 6'd63;
        @(negedge clk);
        ack_valid = 1'b0; done_valid = 1'b0;
        check("R11 out-of-range id ignored", 64'(active_out), 64'h0);

        // R12: request rise against pending-clear write on line 7
        @(negedge clk);
        irq_in[7] = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd6; bus_wdata = 32'h80;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        bus_read(4'd4, rd);
        check("R12 rise beats pending clear", 64'(rd), 64'h80);
        irq_in[7] = 1'b0;
        // R12: acknowledge and completion of line 3 together
        @(negedge clk);
        ack_valid = 1'b1; ack_id = 6'd3;
        done_valid = 1'b1; done_id = 6'd3;
        @(negedge clk);
        ack_valid = 1'b0; done_valid = 1'b0;
        bus_read(4'd8, rd);
        check("R12 ack beats done", 64'(rd), 64'h8);
        @(negedge clk);
        done_valid = 1'b1; done_id = 6'd3;
        @(negedge clk);
        done_valid = 1'b0;
        check("R11 done after ack", 64'(active_out), 64'h0);

        // R13: read data holds through idle cycles
        bus_read(4'd1, rd);
        check("R13 read value", 64'(rd), 64'h07FF_FFFE);
        bus_addr = 4'd0;
        repeat (3) @(negedge clk);
        check("R13 rdata held", 64'(bus_rdata), 64'h07FF_FFFE);

        // R1: reset in mid-run clears every state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 rdata in reset", 64'(bus_rdata), 64'h0);
        rst = 1'b0;
        bus_read(4'd0, rd);
        check("R1 enable w0 cleared", 64'(rd), 64'h0);
        bus_read(4'd1, rd);
        check("R1 enable w1 cleared", 64'(rd), 64'h0);
        bus_read(4'd4, rd);
        check("R1 pending w0 cleared", 64'(rd), 64'h0);
        check("R1 req_out cleared", 64'(req_out), 64'h0);

        finish_run();
    end

endmodule